// File: doc/BRIEF.md
# Dual-Port RAM with Cross-Port Mailbox Interrupts

This block is a synchronous two-sided memory, 16 bits wide, with a left port and a right port. Each side has its own active-low select, write strobe and output enable, its own address and its own write and read data buses. Either side can read or write any word in any cycle, independently of the other. A read is captured on the clock edge and presented one register later. It is shown on the read bus only while that side's output enable is low.

The two highest addresses can act as doorbells between the sides. The second-highest word (0x1FFE when the depth is 8K) is the left side's inbox. The top word (0x1FFF) is the right side's inbox. When the other side writes a side's inbox, that side's active-low interrupt is raised. The owning side drops it by reading the word. What is stored in the words is left entirely to software. A static enable input turns the doorbells on and off. While the enable is off, both words are plain storage and neither interrupt asserts. Resolving two accesses to the same word is the job of an external arbiter. The depth is a parameter: `ADDR_W` = 13 gives the 8K-word array, and the default of 10 gives 1K words with the inboxes at 0x3FE and 0x3FF.

Top module: `dpram_mbx`

## Requirements
- R1: A write (select low, write strobe low) stores the write data at the addressed word on the clock edge. A read (select low, write strobe high) captures the word on the edge, and the captured value appears on that side's read bus after the same edge.
- R2: While a side's select is high, that side performs no write and its captured read value holds unchanged.
- R3: While a side's output enable is high, its read bus is all zeros. With the enable low, the bus shows the last captured read value.
- R4: Both sides operate in the same cycle. A word written by one side can be read by the other side on the following cycle. A read and a write of the same word in the same cycle return the old contents. When both sides write the same word in the same cycle, the right side's data is kept.
- R5: With the doorbells enabled, a right-side write to address 2^ADDR_W-2 drives the left interrupt low after that edge.
- R6: With the doorbells enabled, a left-side read of address 2^ADDR_W-2 returns the left interrupt high after that edge.
- R7: With the doorbells enabled, a left-side write to address 2^ADDR_W-1 drives the right interrupt low. A right-side read of that address returns it high.
- R8: When the set and the clear of the same interrupt occur on the same edge, the interrupt ends up low.
- R9: A side writing its own inbox, or reading the other side's inbox, leaves both interrupts unchanged. Inbox words read back the data written like any other word.
- R10: While the doorbell enable is low, both interrupts are high, any pending interrupt is dropped, and inbox writes raise nothing, even after the enable returns.
- R11: During reset, both interrupts are high and both read buses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mbx_en_i | input | 1 | Doorbell function enable |
| l_cs_ni | input | 1 | Left select, active low |
| l_we_ni | input | 1 | Left write strobe, active low |
| l_oe_ni | input | 1 | Left output enable, active low |
| l_addr_i | input | ADDR_W | Left address |
| l_wdata_i | input | DATA_W | Left write data |
| l_rdata_o | output | DATA_W | Left read data |
| l_irq_no | output | 1 | Left interrupt, active low |
| r_cs_ni | input | 1 | Right select, active low |
| r_we_ni | input | 1 | Right write strobe, active low |
| r_oe_ni | input | 1 | Right output enable, active low |
| r_addr_i | input | ADDR_W | Right address |
| r_wdata_i | input | DATA_W | Right write data |
| r_rdata_o | output | DATA_W | Right read data |
| r_irq_no | output | 1 | Right interrupt, active low |

## Verification
The bench tests the doorbells in each direction, with both side roles: the one that sets and the one that clears. If the two inboxes were swapped, or the set and clear were wired to the wrong side, the wrong interrupt would move. It drives a set and a clear of the same interrupt on one edge, which catches a design that lets the clear win and loses a message. It checks self-writes and cross-reads of the inboxes, which a loose address decode would turn into false interrupts or false clears. It also turns the enable off with an interrupt pending, which a design that only gates the set would leave stuck low. On the plain-memory side, it checks read-before-write on a shared word, the right side winning a double write, a deselected side with its strobe asserted, and gated output data. A random mixed-traffic phase follows, compared against a behavioural model on every clock.

// File: rtl/dpram_mbx_pkg.sv
package dpram_mbx_pkg;
  typedef enum logic {SIDE_L = 1'b0, SIDE_R = 1'b1} side_e;

  typedef struct packed {
    logic rd;
    logic wr;
  } acc_t;

  localparam int unsigned NUM_SIDES = 2;
endpackage

// File: rtl/dpram_mbx_port.sv
module dpram_mbx_port
  import dpram_mbx_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 16,
  parameter side_e       SIDE   = SIDE_L
) (
  input  logic              cs_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] rdq_i,
  output acc_t              acc_o,
  output logic              own_hit_o,
  output logic              peer_hit_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [ADDR_W-1:0] MBX_TOP = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] MBX_LOW = MBX_TOP - 1'b1;

  logic [ADDR_W-1:0] own_addr, peer_addr;

  generate
    if (SIDE == SIDE_L) begin : g_left
      assign own_addr  = MBX_LOW;
      assign peer_addr = MBX_TOP;
    end else begin : g_right
      assign own_addr  = MBX_TOP;
      assign peer_addr = MBX_LOW;
    end
  endgenerate

  assign acc_o.rd   = !cs_ni &&  we_ni;
  assign acc_o.wr   = !cs_ni && !we_ni;
  assign own_hit_o  = (addr_i == own_addr);
  assign peer_hit_o = (addr_i == peer_addr);
  // no tristate inside the chip: disabled output reads as zero
  assign rdata_o    = oe_ni ? '0 : rdq_i;
endmodule

// File: rtl/dpram_mbx_core.sv
module dpram_mbx_core
  import dpram_mbx_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  acc_t              l_acc_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  output logic [DATA_W-1:0] l_rdq_o,
  input  acc_t              r_acc_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  output logic [DATA_W-1:0] r_rdq_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  // right write placed last: it wins a same-word double write
  always_ff @(posedge clk_i) begin
    if (l_acc_i.wr) mem_q[l_addr_i] <= l_wdata_i;
    if (r_acc_i.wr) mem_q[r_addr_i] <= r_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l_rdq_o <= '0;
      r_rdq_o <= '0;
    end else begin
      if (l_acc_i.rd) l_rdq_o <= mem_q[l_addr_i];
      if (r_acc_i.rd) r_rdq_o <= mem_q[r_addr_i];
    end
  end

  a_r2_l_rd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !l_acc_i.rd |=> $stable(l_rdq_o));
  a_r2_r_rd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !r_acc_i.rd |=> $stable(r_rdq_o));
  a_r2_no_access_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(l_acc_i.rd && l_acc_i.wr) && !(r_acc_i.rd && r_acc_i.wr));
endmodule

// File: rtl/dpram_mbx_flags.sv
module dpram_mbx_flags
  import dpram_mbx_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic [NUM_SIDES-1:0] set_i,
  input  logic [NUM_SIDES-1:0] clr_i,
  output logic [NUM_SIDES-1:0] irq_no
);
  for (genvar g = 0; g < NUM_SIDES; g++) begin : g_flag
    logic pend_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        pend_q <= 1'b0;
      else if (!en_i)     pend_q <= 1'b0;
      else if (set_i[g])  pend_q <= 1'b1;   // set beats clear
      else if (clr_i[g])  pend_q <= 1'b0;
    end

    assign irq_no[g] = !pend_q;

    a_r5_r7_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && set_i[g]) |=> !irq_no[g]);
    a_r6_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && clr_i[g] && !set_i[g]) |=> irq_no[g]);
    a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && set_i[g] && clr_i[g]) |=> !irq_no[g]);
    a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !set_i[g] && !clr_i[g]) |=> $stable(irq_no[g]));
    a_r10_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> irq_no[g]);
  end
endmodule

// File: rtl/dpram_mbx.sv
module dpram_mbx
  import dpram_mbx_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mbx_en_i,
  input  logic              l_cs_ni,
  input  logic              l_we_ni,
  input  logic              l_oe_ni,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  output logic [DATA_W-1:0] l_rdata_o,
  output logic              l_irq_no,
  input  logic              r_cs_ni,
  input  logic              r_we_ni,
  input  logic              r_oe_ni,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  output logic [DATA_W-1:0] r_rdata_o,
  output logic              r_irq_no
);
  acc_t              l_acc, r_acc;
  logic              l_own, l_peer, r_own, r_peer;
  logic [DATA_W-1:0] l_rdq, r_rdq;
  logic [NUM_SIDES-1:0] set, clr, irq_n;

  dpram_mbx_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIDE(SIDE_L)) u_port_l (
    .cs_ni(l_cs_ni), .we_ni(l_we_ni), .oe_ni(l_oe_ni), .addr_i(l_addr_i),
    .rdq_i(l_rdq), .acc_o(l_acc), .own_hit_o(l_own), .peer_hit_o(l_peer),
    .rdata_o(l_rdata_o)
  );

  dpram_mbx_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIDE(SIDE_R)) u_port_r (
    .cs_ni(r_cs_ni), .we_ni(r_we_ni), .oe_ni(r_oe_ni), .addr_i(r_addr_i),
    .rdq_i(r_rdq), .acc_o(r_acc), .own_hit_o(r_own), .peer_hit_o(r_peer),
    .rdata_o(r_rdata_o)
  );

  dpram_mbx_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .l_acc_i(l_acc), .l_addr_i(l_addr_i), .l_wdata_i(l_wdata_i), .l_rdq_o(l_rdq),
    .r_acc_i(r_acc), .r_addr_i(r_addr_i), .r_wdata_i(r_wdata_i), .r_rdq_o(r_rdq)
  );

  // a side's flag is set by the partner writing into it, cleared by its own read
  assign set[SIDE_L] = r_acc.wr && r_peer;
  assign clr[SIDE_L] = l_acc.rd && l_own;
  assign set[SIDE_R] = l_acc.wr && l_peer;
  assign clr[SIDE_R] = r_acc.rd && r_own;

  dpram_mbx_flags u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(mbx_en_i),
    .set_i(set), .clr_i(clr), .irq_no(irq_n)
  );

  assign l_irq_no = irq_n[SIDE_L];
  assign r_irq_no = irq_n[SIDE_R];

  a_r11_reset_irq: assert property (@(posedge clk_i)
    !rst_ni |-> (l_irq_no && r_irq_no));
endmodule

// File: tb/dpram_mbx_tb.sv
module dpram_mbx_tb_top;
  localparam int AW = 10;
  localparam int DW = 16;
  localparam logic [AW-1:0] MBL = {AW{1'b1}} - 1'b1;
  localparam logic [AW-1:0] MBR = {AW{1'b1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1;
  logic l_cs = 1'b1, l_we = 1'b1, l_oe = 1'b0;
  logic r_cs = 1'b1, r_we = 1'b1, r_oe = 1'b0;
  logic [AW-1:0] l_a = '0, r_a = '0;
  logic [DW-1:0] l_d = '0, r_d = '0;
  logic [DW-1:0] l_q, r_q;
  logic l_irq, r_irq;

  int n_chk = 0, n_bad = 0;
  string req = "R11";

  always #10 clk = ~clk;

  dpram_mbx #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mbx_en_i(en),
    .l_cs_ni(l_cs), .l_we_ni(l_we), .l_oe_ni(l_oe), .l_addr_i(l_a),
    .l_wdata_i(l_d), .l_rdata_o(l_q), .l_irq_no(l_irq),
    .r_cs_ni(r_cs), .r_we_ni(r_we), .r_oe_ni(r_oe), .r_addr_i(r_a),
    .r_wdata_i(r_d), .r_rdata_o(r_q), .r_irq_no(r_irq)
  );

  // behavioural reference model
  logic [DW-1:0] m_mem [int];
  logic [DW-1:0] m_lrd = '0, m_rrd = '0;
  bit m_lflag = 0, m_rflag = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lrd = '0; m_rrd = '0; m_lflag = 0; m_rflag = 0;
    end else begin
      logic [DW-1:0] ol, orr;
      bit lrd, lwr, rrd, rwr;
      lrd = !l_cs && l_we; lwr = !l_cs && !l_we;
      rrd = !r_cs && r_we; rwr = !r_cs && !r_we;
      ol  = m_mem.exists(int'(l_a)) ? m_mem[int'(l_a)] : '0;
      orr = m_mem.exists(int'(r_a)) ? m_mem[int'(r_a)] : '0;
      if (lrd) m_lrd = ol;
      if (rrd) m_rrd = orr;
      if (!en) begin
        m_lflag = 0; m_rflag = 0;
      end else begin
        if (rwr && r_a == MBL) m_lflag = 1;
        else if (lrd && l_a == MBL) m_lflag = 0;
        if (lwr && l_a == MBR) m_rflag = 1;
        else if (rrd && r_a == MBR) m_rflag = 0;
      end
      if (lwr) m_mem[int'(l_a)] = l_d;
      if (rwr) m_mem[int'(r_a)] = r_d;
    end
  end

  task automatic chk(string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("l_rdata", l_q, l_oe ? '0 : m_lrd);
    chk("r_rdata", r_q, r_oe ? '0 : m_rrd);
    chk("l_irq_n", {15'd0, l_irq}, {15'd0, !m_lflag});
    chk("r_irq_n", {15'd0, r_irq}, {15'd0, !m_rflag});
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare();
    l_cs = 1'b1; l_we = 1'b1; r_cs = 1'b1; r_we = 1'b1;
  endtask

  task automatic lw(logic [AW-1:0] a, logic [DW-1:0] d);
    l_cs = 0; l_we = 0; l_a = a; l_d = d;
  endtask
  task automatic lr(logic [AW-1:0] a);
    l_cs = 0; l_we = 1; l_a = a;
  endtask
  task automatic rw(logic [AW-1:0] a, logic [DW-1:0] d);
    r_cs = 0; r_we = 0; r_a = a; r_d = d;
  endtask
  task automatic rr(logic [AW-1:0] a);
    r_cs = 0; r_we = 1; r_a = a;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R11: reset state
    req = "R11";
    @(negedge clk); compare();
    @(negedge clk); compare();
    rst_n = 1'b1;
    @(negedge clk); compare();

    // R1: each side writes and reads back
    req = "R1";
    lw(10'd1, 16'h1111); tick();
    lw(10'd2, 16'h2222); tick();
    rw(10'd3, 16'h3333); tick();
    lr(10'd1); tick();
    lr(10'd2); tick();
    rr(10'd3); tick();

    // R4: cross-side, read-before-write, double write
    req = "R4";
    lw(10'd5, 16'hA5A5); rr(10'd1); tick();
    rr(10'd5); lr(10'd3); tick();
    lw(10'd5, 16'h5A5A); rr(10'd5); tick();
    rr(10'd5); tick();
    lw(10'd9, 16'hAAAA); rw(10'd9, 16'hBBBB); tick();
    lr(10'd9); rr(10'd9); tick();

    // R2: deselected side with strobe asserted does nothing
    req = "R2";
    lw(10'd1, 16'hDEAD); l_cs = 1'b1; tick();
    r_we = 1'b1; r_a = 10'd2; tick();
    lr(10'd1); tick();

    // R3: output enable gating
    req = "R3";
    l_oe = 1'b1; lr(10'd2); tick();
    l_oe = 1'b0; tick();
    r_oe = 1'b1; tick();
    r_oe = 1'b0; tick();

    // R5/R6: left doorbell
    req = "R5";
    rw(MBL, 16'hC001); tick();
    lr(10'd1); tick();
    req = "R6";
    lr(MBL); tick();
    tick();

    // R7: right doorbell
    req = "R7";
    lw(MBR, 16'hC002); tick();
    rr(10'd2); tick();
    rr(MBR); tick();

    // R8: set and clear on the same edge
    req = "R8";
    rw(MBL, 16'h0101); tick();
    rw(MBL, 16'h0202); lr(MBL); tick();
    lw(MBR, 16'h0303); tick();
    lw(MBR, 16'h0404); rr(MBR); tick();
    lr(MBL); rr(MBR); tick();

    // R9: own-inbox writes, peer-inbox reads
    req = "R9";
    lw(MBL, 16'h7777); rw(MBR, 16'h8888); tick();
    lr(MBR); rr(MBL); tick();
    rw(MBL, 16'h9999); tick();
    rr(MBL); tick();
    lr(MBL); tick();

    // R10: disable drops pending flag, inboxes are plain RAM
    req = "R10";
    lw(MBR, 16'h4444); tick();
    en = 1'b0; tick();
    rw(MBL, 16'h5555); lw(MBR, 16'h6666); tick();
    lr(MBL); rr(MBR); tick();
    en = 1'b1; tick();
    tick();

    // mixed traffic over low words and inboxes
    req = "R1";
    en = 1'b0;
    for (int i = 0; i < 16; i++) begin
      lw(i[AW-1:0], 16'(i * 3 + 1)); tick();
    end
    lw(MBL, 16'h0); rw(MBR, 16'h0); tick();
    en = 1'b1;
    req = "R4";
    for (int i = 0; i < 400; i++) begin
      int sel;
      logic [AW-1:0] a;
      sel = $urandom_range(0, 17);
      a = (sel == 16) ? MBL : (sel == 17) ? MBR : sel[AW-1:0];
      case ($urandom_range(0, 2))
        0: lw(a, 16'($urandom));
        1: lr(a);
        default: ;
      endcase
      sel = $urandom_range(0, 17);
      a = (sel == 16) ? MBL : (sel == 17) ? MBR : sel[AW-1:0];
      case ($urandom_range(0, 2))
        0: rw(a, 16'($urandom));
        1: rr(a);
        default: ;
      endcase
      l_oe = ($urandom_range(0, 4) == 0);
      r_oe = ($urandom_range(0, 4) == 0);
      if ($urandom_range(0, 40) == 0) en = ~en;
      tick();
    end

    finish_run();
  end
endmodule